// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block keeps a position or event count. It can run in two ways. In the first, it counts its own clock, divided by a programmable prescaler. In the second, it counts the edges of two phase inputs, A and B, from an incremental encoder. A two-bit mode input picks the source and the counting resolution. The phase inputs are resynchronised to the block clock inside the block. Edges are found by comparing each synchronised sample with the sample taken one cycle earlier.

The count runs between zero and a programmable ceiling and wraps in both directions. Each wrap gives a one-cycle update pulse. The counter value can be loaded directly, but only with a value no larger than the current ceiling. A status output shows whether the last step counted down. The prescaler setting is double-buffered: a new value takes effect at the next wrap or when the force-update strobe is pulsed. A new ceiling takes effect at once.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count is 0, the direction flag is 0, the update pulse is low, the ceiling is all ones, and both the active and the pending prescaler values are 0.
- R2: With mode 0 (increment), the count rises by one on each prescaler tick while `en` is 1, and the phase inputs have no effect. With `en` at 0, the count holds in every mode.
- R3: With mode 1 (x2 on A), a change of synchronised A is one step. The step is up when the new A differs from B and down otherwise. Changes of B alone do not count.
- R4: With mode 2 (x2 on B), a change of synchronised B is one step. The step is up when the new B equals A and down otherwise. Changes of A alone do not count.
- R5: With mode 3 (x4), a change of either phase is one step, using the rule of R3 for A and the rule of R4 for B.
- R6: `dir_down` is 1 after a down step and 0 after an up step. It keeps its value when no step occurs, and reads 0 in the cycle after any cycle spent in mode 0.
- R7: With an active prescaler value N, mode 0 steps once every N+1 enabled cycles. A value written to the prescaler becomes active only at a wrap or at a force-update.
- R8: An up step from a count at or above the ceiling gives 0. A down step from 0 gives the ceiling. Each wrap raises `update_evt` for exactly the cycle in which the new count appears.
- R9: A counter write with a value no greater than the current ceiling loads that value and takes priority over a step in the same cycle. A larger value is ignored, and any step in that cycle still happens.
- R10: A ceiling write takes effect at the next clock edge, with no buffering. A counter write in the same cycle is checked against the old ceiling.
- R11: `force_upd` copies the pending prescaler value into the active one and restarts the divider phase. It leaves the count unchanged and does not pulse `update_evt`.
- R12: If both synchronised phases change in the same cycle, the count does not change in any encoder mode.
- R13: A phase change that is set up before clock edge k reaches the count at edge k+2. This is two synchroniser flops and one previous-sample register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable |
| mode | input | 2 | 0 increment, 1 x2 on A, 2 x2 on B, 3 x4 |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| ceil_in | input | CNT_W | New ceiling value |
| ceil_wr | input | 1 | Ceiling write strobe |
| psc_in | input | PSC_W | New prescaler value N (divide by N+1) |
| psc_wr | input | 1 | Prescaler write strobe (pending value) |
| cnt_in | input | CNT_W | New counter value |
| cnt_wr | input | 1 | Counter write strobe |
| force_upd | input | 1 | Reload the active prescaler and restart the divider |
| count | output | CNT_W | Current count |
| dir_down | output | 1 | 1 when the last step counted down |
| update_evt | output | 1 | One-cycle pulse on a wrap |

## Verification
The bench builds the counter with CNT_W = 8 and PSC_W = 3. With these values, wraps at a full-range ceiling and at small random ceilings occur within a few hundred steps. Every prescaler value can be reached, and the divider's own wrap, after a lower value is loaded, also occurs. Random phase activity, with about one cycle in nine changing both phases at once, exercises the invalid-transition rule in every encoder mode. The random writes include counter loads above the current ceiling.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    MODE_INC = 2'd0,
    MODE_X2A = 2'd1,
    MODE_X2B = 2'd2,
    MODE_X4  = 2'd3
  } qmode_e;
endpackage

// File: rtl/qenc_sync.sv
// Two-flop synchroniser per bit plus a previous-sample register for edge detection.
module qenc_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q, p_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        p_q  <= 1'b0;
      end else begin
        s1_q <= din[i];
        s2_q <= s1_q;
        p_q  <= s2_q;
      end
    end
    assign cur[i] = s2_q;
    assign prv[i] = p_q;
  end
endmodule

// File: rtl/qenc_decode.sv
// Turns phase samples and the mode into a step request and its direction.
module qenc_decode
  import qenc_pkg::*;
(
  input  qmode_e mode,
  input  logic   a_cur,
  input  logic   a_prv,
  input  logic   b_cur,
  input  logic   b_prv,
  output logic   step,
  output logic   up
);
  logic a_chg, b_chg, both, a_up, b_up;

  always_comb begin
    a_chg = a_cur ^ a_prv;
    b_chg = b_cur ^ b_prv;
    both  = a_chg & b_chg;
    a_up  = a_cur ^ b_cur;
    b_up  = ~(a_cur ^ b_cur);
    step  = 1'b0;
    up    = 1'b1;
    unique case (mode)
      MODE_INC: begin
        step = 1'b0;
        up   = 1'b1;
      end
      MODE_X2A: begin
        step = a_chg & ~both;
        up   = a_up;
      end
      MODE_X2B: begin
        step = b_chg & ~both;
        up   = b_up;
      end
      MODE_X4: begin
        step = (a_chg | b_chg) & ~both;
        up   = a_chg ? a_up : b_up;
      end
      default: begin
        step = 1'b0;
        up   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/qenc_prescale.sv
// Internal-clock divider with a pending and an active divide value.
module qenc_prescale #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [PSC_W-1:0] psc_in,
  input  logic             psc_wr,
  input  logic             reload,
  input  logic             clear,
  output logic             tick
);
  logic [PSC_W-1:0] pre_q, pre_n, act_q, act_n, pc_q, pc_n;

  assign tick = tick_en && (pc_q == act_q);

  always_comb begin
    pre_n = psc_wr ? psc_in : pre_q;
    act_n = reload ? pre_q : act_q;
    if (clear)        pc_n = '0;
    else if (tick)    pc_n = '0;
    else if (tick_en) pc_n = pc_q + 1'b1;
    else              pc_n = pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
      pc_q  <= '0;
    end else begin
      pre_q <= pre_n;
      act_q <= act_n;
      pc_q  <= pc_n;
    end
  end
endmodule

// File: rtl/qenc_counter.sv
// Up/down position counter with four counting modes, ceiling wrap and update pulse.
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic [CNT_W-1:0] ceil_in,
  input  logic             ceil_wr,
  input  logic [PSC_W-1:0] psc_in,
  input  logic             psc_wr,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             cnt_wr,
  input  logic             force_upd,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             update_evt
);
  localparam logic [CNT_W-1:0] CEIL_RST = {CNT_W{1'b1}};

  qmode_e mode_e;
  logic [1:0] ph_cur, ph_prv;
  logic a_cur, a_prv, b_cur, b_prv;
  logic enc_step, enc_up, pre_tick, is_inc;
  logic step_any, up_any, wrap, wr_ok;
  logic [CNT_W-1:0] cnt_q, cnt_n, ceil_q, ceil_n;
  logic dir_q, dir_n, upd_q;

  assign mode_e = qmode_e'(mode);
  assign is_inc = (mode_e == MODE_INC);

  qenc_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({phase_b, phase_a}),
    .cur(ph_cur), .prv(ph_prv)
  );
  assign a_cur = ph_cur[0];
  assign a_prv = ph_prv[0];
  assign b_cur = ph_cur[1];
  assign b_prv = ph_prv[1];

  qenc_decode u_dec (
    .mode(mode_e), .a_cur(a_cur), .a_prv(a_prv), .b_cur(b_cur), .b_prv(b_prv),
    .step(enc_step), .up(enc_up)
  );

  qenc_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .tick_en(is_inc && en),
    .psc_in(psc_in), .psc_wr(psc_wr), .reload(wrap || force_upd),
    .clear(force_upd), .tick(pre_tick)
  );

  always_comb begin
    step_any = is_inc ? pre_tick : (en && enc_step);
    up_any   = is_inc ? 1'b1 : enc_up;
    wr_ok    = cnt_wr && (cnt_in <= ceil_q);
    wrap     = 1'b0;
    cnt_n    = cnt_q;
    if (wr_ok) begin
      cnt_n = cnt_in;
    end else if (step_any) begin
      if (up_any) begin
        if (cnt_q >= ceil_q) begin
          cnt_n = '0;
          wrap  = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_n = ceil_q;
          wrap  = 1'b1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    end
    ceil_n = ceil_wr ? ceil_in : ceil_q;
    if (is_inc)        dir_n = 1'b0;
    else if (step_any) dir_n = ~up_any;
    else               dir_n = dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ceil_q <= CEIL_RST;
      dir_q  <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      ceil_q <= ceil_n;
      dir_q  <= dir_n;
      upd_q  <= wrap;
    end
  end

  assign count      = cnt_q;
  assign dir_down   = dir_q;
  assign update_evt = upd_q;
endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       mode,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_in,
  input logic [CNT_W-1:0] count,
  input logic             dir_down,
  input logic             update_evt,
  input logic [CNT_W-1:0] ceil_q,
  input logic             a_cur,
  input logic             a_prv,
  input logic             b_cur,
  input logic             b_prv
);
  a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(count));

  a_r6_inc_reads_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> !dir_down);

  a_r8_up_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (update_evt && !dir_down) |-> (count == '0));

  a_r8_down_wrap_ceil: assert property (@(posedge clk) disable iff (!rst_n)
    (update_evt && dir_down) |-> (count == $past(ceil_q)));

  a_r9_reject_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && (cnt_in > ceil_q) && !en) |=> $stable(count));

  a_r12_no_double_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode != 2'd0) && !cnt_wr && (a_cur != a_prv) && (b_cur != b_prv)) |=> $stable(count));
endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cnt_wr(cnt_wr), .cnt_in(cnt_in),
  .count(count), .dir_down(dir_down), .update_evt(update_evt), .ceil_q(ceil_q),
  .a_cur(a_cur), .a_prv(a_prv), .b_cur(b_cur), .b_prv(b_prv)
);

// File: tb/qenc_counter_test.sv
`timescale 1ns/1ps
module qenc_counter_test;
  localparam int CW = 8;
  localparam int PW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic pa = 1'b0, pb = 1'b0;
  logic [CW-1:0] ceil_in = '0;
  logic ceil_wr = 1'b0;
  logic [PW-1:0] psc_in = '0;
  logic psc_wr = 1'b0;
  logic [CW-1:0] cnt_in = '0;
  logic cnt_wr = 1'b0;
  logic force_upd = 1'b0;
  logic [CW-1:0] count;
  logic dir_down, update_evt;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  qenc_counter #(.CNT_W(CW), .PSC_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .phase_a(pa), .phase_b(pb),
    .ceil_in(ceil_in), .ceil_wr(ceil_wr), .psc_in(psc_in), .psc_wr(psc_wr),
    .cnt_in(cnt_in), .cnt_wr(cnt_wr), .force_upd(force_upd),
    .count(count), .dir_down(dir_down), .update_evt(update_evt)
  );

  // behavioural reference
  int ma1, ma2, map_, mb1, mb2, mbp, mcnt, mceil, mpre, mact, mpc, mdir, mupd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma1 = 0; ma2 = 0; map_ = 0; mb1 = 0; mb2 = 0; mbp = 0;
      mcnt = 0; mceil = CMAX; mpre = 0; mact = 0; mpc = 0; mdir = 0; mupd = 0;
    end else begin
      int st, u, w, ac, bc;
      st = 0; u = 1; w = 0;
      ac = (ma2 != map_); bc = (mb2 != mbp);
      if (mode == 0) begin
        if (en) begin
          if (mpc == mact) begin mpc = 0; st = 1; end
          else mpc = (mpc + 1) % (1 << PW);
        end
      end else if (en && !(ac && bc)) begin
        if ((mode == 1 || mode == 3) && ac) begin st = 1; u = (ma2 != mb2); end
        if ((mode == 2 || mode == 3) && bc) begin st = 1; u = (mb2 == ma2); end
      end
      if (cnt_wr && int'(cnt_in) <= mceil) mcnt = cnt_in;
      else if (st) begin
        if (u) begin
          if (mcnt >= mceil) begin mcnt = 0; w = 1; end else mcnt = mcnt + 1;
        end else begin
          if (mcnt == 0) begin mcnt = mceil; w = 1; end else mcnt = mcnt - 1;
        end
      end
      mupd = w;
      if (mode == 0) mdir = 0; else if (st) mdir = !u;
      if (force_upd) begin mpc = 0; mact = mpre; end
      else if (w) mact = mpre;
      if (psc_wr) mpre = psc_in;
      if (ceil_wr) mceil = ceil_in;
      map_ = ma2; ma2 = ma1; ma1 = pa;
      mbp = mb2; mb2 = mb1; mb1 = pb;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      check(mode_tag(mode), count, mcnt);
      check("R6 dir", dir_down, mdir);
      check("R8 update", update_evt, mupd);
    end
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic idle_strobes();
    ceil_wr = 0; psc_wr = 0; cnt_wr = 0; force_upd = 0;
  endtask

  task automatic cyc_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    idle_strobes();
  endtask

  task automatic rand_run(input logic [1:0] m, input int n);
    mode = m;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle_strobes();
      en = (($urandom % 8) != 0);
      if ($urandom % 3 == 0) pa = ~pa;
      if ($urandom % 3 == 0) pb = ~pb;
      if ($urandom % 40 == 0) begin cnt_wr = 1; cnt_in = CW'($urandom); end
      if ($urandom % 60 == 0) begin
        ceil_wr = 1;
        ceil_in = ($urandom % 2) ? CW'($urandom % 16) : CW'($urandom);
      end
      if ($urandom % 50 == 0) begin psc_wr = 1; psc_in = PW'($urandom); end
      if ($urandom % 70 == 0) force_upd = 1;
    end
    @(negedge clk);
    idle_strobes();
  endtask

  initial begin
    int base;
    #1;
    check("R1 count", count, 0);
    check("R1 dir", dir_down, 0);
    check("R1 update", update_evt, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    check("R1 count after release", count, 0);

    // R7: divide by 3 after a force-update
    psc_in = 3'd2; psc_wr = 1; cyc_n(1);
    force_upd = 1; cyc_n(1);
    check("R11 no pulse", update_evt, 0);
    en = 1; cyc_n(9); en = 0;
    check("R7 count after 9 enabled cycles", count, 3);
    en = 1; cyc_n(2); en = 0;
    force_upd = 1; cyc_n(1);
    check("R11 count unchanged", count, 3);
    en = 1; cyc_n(2); en = 0;
    check("R11 divider restarted", count, 3);
    cyc_n(1); en = 1; cyc_n(1); en = 0;
    check("R11 tick after restart", count, 4);

    // R9/R10/R8
    psc_in = 0; psc_wr = 1; cyc_n(1);
    force_upd = 1; cyc_n(1);
    cnt_in = 8'd50; cnt_wr = 1; ceil_in = 8'd100; ceil_wr = 1; cyc_n(1);
    check("R9 load accepted", count, 50);
    cnt_in = 8'd150; cnt_wr = 1; cyc_n(1);
    check("R10 reject above new ceiling", count, 50);
    cnt_in = 8'd100; cnt_wr = 1; cyc_n(1);
    check("R9 load at ceiling", count, 100);
    en = 1; cyc_n(1); en = 0;
    check("R8 up wrap to 0", count, 0);
    check("R8 wrap pulse", update_evt, 1);
    cyc_n(1);
    check("R8 pulse one cycle", update_evt, 0);

    // R13 latency and R12 double change in x4
    mode = 2'd3; en = 1; cyc_n(4);
    base = count;
    pa = 1; cyc_n(2);
    check("R13 no change before third edge", count, base);
    cyc_n(1);
    check("R13 step at third edge", count, base + 1);
    check("R5 dir up", dir_down, 0);
    cyc_n(3);
    base = count;
    pa = 0; pb = 1; cyc_n(5);
    check("R12 double change ignored", count, base);
    pa = 1; pb = 0; cyc_n(5);
    check("R12 double change ignored again", count, base);
    en = 0; cyc_n(2);

    rand_run(2'd0, 1500);
    rand_run(2'd1, 1500);
    rand_run(2'd2, 1500);
    rand_run(2'd3, 1500);
    rand_run(2'd1, 800);
    cyc_n(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule